// File: doc/BRIEF.md
# Programmable Local Interrupt Timer

This block is a countdown timer owned by one processor. A free-running tick input is thinned by a power-of-two prescaler, and each prescaled tick lowers a 32-bit counter by one. Software sets the timer up over a small word-wide register port. Through that port it chooses the prescale divisor and writes an entry that holds the interrupt vector, a mask flag and a mode flag. Writing the start value launches a count. When the counter reaches zero and the entry is not masked, the block raises a one-cycle request that carries the programmed 8-bit vector. The request goes to the interrupt controller next to the block.

The timer has two modes. In one-shot mode the counter stops at zero and fires once. In periodic mode the counter reloads after its zero state, so the reload period is the start value plus one prescaled tick. A start value of zero keeps the timer idle in either mode. The live count is readable at any time with no added read latency.

The control core is a three-state machine:
- ST_IDLE: stopped, count zero.
- ST_RUN: counting down.
- ST_DONE: a one-shot expired and holds at zero.

Its transitions are:
- T_LOAD: a start-value write, from any state. It goes to ST_RUN, or to ST_IDLE when the value is zero.
- T_EXPIRE: in ST_RUN the count moves from 1 to 0. A one-shot goes to ST_DONE; a periodic timer stays in ST_RUN.
- T_RELOAD: in ST_RUN, periodic mode, at zero: the count reloads to the start value.
- T_STOP: in ST_RUN, one-shot mode, the count is already zero. This happens after a mode change, and it goes to ST_DONE.
- T_RESUME: in ST_DONE, after the entry has been switched to periodic, a prescaled tick reloads the count and goes to ST_RUN.

Top module: `lt_timer`

## Requirements
- R1: After reset the vector entry reads 0x0001_0000 (masked, one-shot, vector 0). The divide register, start value and current count read 0, and irq_valid is low.
- R2: The divide register (select 0) keeps only write-data bits 0, 1 and 3. Every other bit reads back as zero.
- R3: The divide code is {div[3], div[1], div[0]}. The prescaler shift is (code + 1) mod 8 and the divisor is 2^shift, so register value 0x0 divides by 2, 0x3 by 16, 0x8 by 32 and 0xB by 1.
- R4: In one-shot mode (entry bit 17 = 0) the current count (select 3) equals the start value minus the prescaled ticks elapsed. It saturates at zero and gives exactly one request.
- R5: In periodic mode (entry bit 17 = 1) a request occurs every start value + 1 prescaled ticks. The first request comes start value prescaled ticks after the write.
- R6: A start value of zero (select 2) produces no request in either mode, and the count reads zero. Writing zero during a periodic run stops it.
- R7: A start-value write restarts both the count and the prescaler phase from the write edge. A pending expiry of the previous count is discarded.
- R8: While the entry mask bit 16 is set, no request is produced, but the count still runs.
- R9: irq_valid is a one-cycle pulse. It is high in the first cycle the count reads zero, and irq_vector then equals entry bits 7:0.
- R10: A cycle with tick_in low does not advance the prescaler or the count.
- R11: The vector entry (select 1) keeps bits 17, 16 and 7:0 only. Other bits read back as zero.
- R12: Switching an expired one-shot timer to periodic resumes it: the next prescaled tick reloads the start value and counting continues.
- R13: Writes to the current-count select (3) have no effect on any register or on the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_in | input | 1 | Free-running time-base tick, one cycle per tick |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write select: 0 divide, 1 vector entry, 2 start value, 3 current count (read-only) |
| wr_data | input | 32 | Write data |
| rd_sel | input | 2 | Read select, same encoding as wr_sel |
| rd_data | output | 32 | Combinational read data |
| irq_valid | output | 1 | One-cycle expiry request |
| irq_vector | output | 8 | Vector carried with the request |

## Verification
The bench predicts the exact cycle of every request from the divisor, the start value and the write edge, and queues it. Any request that comes early or late, is missing, or appears with nothing queued is reported.

It goes after these corners:
- The scrambled divide code: a design that left the bit order or the +1 wrap unscrambled would fire at the wrong multiple of the tick.
- The periodic off-by-one: a reload period of N instead of N + 1 shifts every later request.
- A restart written in mid-count: a design that kept the old prescaler phase or the old expiry fires one cycle late or fires twice.
- Masked runs, zero start values, paused ticks and a one-shot-to-periodic switch after expiry: a design that stopped counting under the mask, fired on zero, or never resumed would show a wrong count or a missing request.

// File: rtl/lt_pkg.sv
package lt_pkg;

    // register selects (shared by write and read paths)
    localparam logic [1:0] SEL_DIV  = 2'd0;
    localparam logic [1:0] SEL_VEC  = 2'd1;
    localparam logic [1:0] SEL_INIT = 2'd2;
    localparam logic [1:0] SEL_CUR  = 2'd3;

    // field positions inside the vector entry
    localparam int ENTRY_PERIODIC_BIT = 17;
    localparam int ENTRY_MASK_BIT     = 16;

    // divide register: bits that are kept
    localparam logic [3:0] DIV_KEEP = 4'b1011;

    // width of the prescaler shift value
    localparam int SHIFT_W = 3;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } tmr_state_e;

endpackage

// File: rtl/lt_regs.sv
module lt_regs
    import lt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32,
    parameter int VEC_W  = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [1:0]          wr_sel,
    input  logic [DATA_W-1:0]   wr_data,
    output logic [3:0]          div_q,
    output logic [VEC_W-1:0]    vec_q,
    output logic                mask_q,
    output logic                periodic_q,
    output logic [CNT_W-1:0]    init_q,
    output logic                load_o,
    output logic [SHIFT_W-1:0]  shift_o
);

    logic [SHIFT_W-1:0] code;

    // start-value write is seen by the counter at the same edge
    assign load_o = wr_en && (wr_sel == SEL_INIT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q      <= '0;
            vec_q      <= '0;
            mask_q     <= 1'b1;
            periodic_q <= 1'b0;
            init_q     <= '0;
        end else if (wr_en) begin
            unique case (wr_sel)
                SEL_DIV: div_q <= wr_data[3:0] & DIV_KEEP;
                SEL_VEC: begin
                    vec_q      <= wr_data[VEC_W-1:0];
                    mask_q     <= wr_data[ENTRY_MASK_BIT];
                    periodic_q <= wr_data[ENTRY_PERIODIC_BIT];
                end
                SEL_INIT: init_q <= wr_data[CNT_W-1:0];
                SEL_CUR: ;  // read-only select
                default: ;
            endcase
        end
    end

    // scrambled divide code, shift wraps modulo 8
    assign code    = {div_q[3], div_q[1:0]};
    assign shift_o = code + SHIFT_W'(1);

    AST_DIV_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_DIV) |=> (div_q[2] == 1'b0)) else $error("divide bit 2 stored"); // R2

    AST_CUR_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_CUR) |=> ($stable(div_q) && $stable(vec_q) && $stable(init_q) && $stable(mask_q))) else $error("write to count select changed a register"); // R13

endmodule

// File: rtl/lt_prescale.sv
module lt_prescale
    import lt_pkg::*;
#(
    parameter int PRE_W = (1 << SHIFT_W) - 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_i,
    input  logic               restart_i,
    input  logic [SHIFT_W-1:0] shift_i,
    output logic               ptick_o
);

    logic [PRE_W-1:0] cnt_q;
    logic [PRE_W-1:0] lim;

    // low 'shift' bits set: the prescaler fires when they are all ones
    for (genvar gi = 0; gi < PRE_W; gi++) begin : g_lim
        assign lim[gi] = (gi < int'(shift_i));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart_i) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            cnt_q <= cnt_q + PRE_W'(1);
        end
    end

    assign ptick_o = tick_i && !restart_i && ((cnt_q & lim) == lim);

    AST_PHASE_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> (cnt_q == '0)) else $error("prescaler phase not cleared"); // R7

    AST_PAUSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !restart_i) |=> $stable(cnt_q)) else $error("prescaler moved without tick"); // R10

endmodule

// File: rtl/lt_count_fsm.sv
module lt_count_fsm
    import lt_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int VEC_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [CNT_W-1:0]  load_val_i,
    input  logic [CNT_W-1:0]  init_i,
    input  logic              periodic_i,
    input  logic              mask_i,
    input  logic [VEC_W-1:0]  vec_i,
    input  logic              ptick_i,
    output logic [CNT_W-1:0]  cur_o,
    output logic              irq_valid_o,
    output logic [VEC_W-1:0]  irq_vec_o
);

    tmr_state_e       state_q, state_d;
    logic [CNT_W-1:0] cur_q, cur_d;
    logic             expire;

    // next-state and next-count
    always_comb begin
        state_d = state_q;
        cur_d   = cur_q;
        expire  = 1'b0;
        if (load_i) begin
            // T_LOAD
            cur_d   = load_val_i;
            state_d = (load_val_i == '0) ? ST_IDLE : ST_RUN;
        end else begin
            unique case (state_q)
                ST_IDLE: ;
                ST_RUN: begin
                    if (ptick_i) begin
                        if (cur_q != '0) begin
                            cur_d = cur_q - CNT_W'(1);
                            if (cur_q == CNT_W'(1)) begin
                                // T_EXPIRE
                                expire = 1'b1;
                                if (!periodic_i) state_d = ST_DONE;
                            end
                        end else if (periodic_i) begin
                            // T_RELOAD
                            cur_d = init_i;
                        end else begin
                            // T_STOP
                            state_d = ST_DONE;
                        end
                    end
                end
                ST_DONE: begin
                    if (periodic_i && ptick_i) begin
                        // T_RESUME
                        cur_d   = init_i;
                        state_d = ST_RUN;
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cur_q   <= '0;
        end else begin
            state_q <= state_d;
            cur_q   <= cur_d;
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_valid_o <= 1'b0;
            irq_vec_o   <= '0;
        end else begin
            irq_valid_o <= expire && !mask_i;
            if (expire) irq_vec_o <= vec_i;
        end
    end

    assign cur_o = cur_q;

    AST_IRQ_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid_o |-> (cur_q == '0)) else $error("request without zero count"); // R9

    AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid_o |=> !irq_valid_o) else $error("request longer than one cycle"); // R9

    AST_MASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid_o |-> !$past(mask_i)) else $error("request while masked"); // R8

    AST_DONE_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE) |-> (cur_q == '0)) else $error("one-shot left zero"); // R4

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (cur_q == '0 && !irq_valid_o)) else $error("idle timer active"); // R6

    AST_COUNT_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!ptick_i && !load_i) |=> $stable(cur_q)) else $error("count moved without tick"); // R10

endmodule

// File: rtl/lt_timer.sv
module lt_timer
    import lt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32,
    parameter int VEC_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_in,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        rd_sel,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq_valid,
    output logic [VEC_W-1:0]  irq_vector
);

    logic [3:0]         div_q;
    logic [VEC_W-1:0]   vec_q;
    logic               mask_q;
    logic               periodic_q;
    logic [CNT_W-1:0]   init_q;
    logic               load;
    logic [SHIFT_W-1:0] shift;
    logic               ptick;
    logic [CNT_W-1:0]   cur;
    logic [DATA_W-1:0]  entry_word;

    lt_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W), .VEC_W(VEC_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .div_q      (div_q),
        .vec_q      (vec_q),
        .mask_q     (mask_q),
        .periodic_q (periodic_q),
        .init_q     (init_q),
        .load_o     (load),
        .shift_o    (shift)
    );

    lt_prescale u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick_in),
        .restart_i (load),
        .shift_i   (shift),
        .ptick_o   (ptick)
    );

    lt_count_fsm #(.CNT_W(CNT_W), .VEC_W(VEC_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (load),
        .load_val_i  (wr_data[CNT_W-1:0]),
        .init_i      (init_q),
        .periodic_i  (periodic_q),
        .mask_i      (mask_q),
        .vec_i       (vec_q),
        .ptick_i     (ptick),
        .cur_o       (cur),
        .irq_valid_o (irq_valid),
        .irq_vec_o   (irq_vector)
    );

    always_comb begin
        entry_word = '0;
        entry_word[VEC_W-1:0]         = vec_q;
        entry_word[ENTRY_MASK_BIT]     = mask_q;
        entry_word[ENTRY_PERIODIC_BIT] = periodic_q;
    end

    // combinational read mux from live state
    always_comb begin
        unique case (rd_sel)
            SEL_DIV:  rd_data = DATA_W'(div_q);
            SEL_VEC:  rd_data = entry_word;
            SEL_INIT: rd_data = DATA_W'(init_q);
            SEL_CUR:  rd_data = DATA_W'(cur);
            default:  rd_data = '0;
        endcase
    end

endmodule

// File: tb/sim_lt_timer.sv
`timescale 1ns/1ps
module sim_lt_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_in = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_sel = 2'd3;
    logic [31:0] rd_data;
    logic        irq_valid;
    logic [7:0]  irq_vector;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;

    int         exp_cyc[$];
    logic [7:0] exp_vec[$];
    string      exp_tag[$];

    lt_timer u0 (
        .clk(clk), .rst_n(rst_n), .tick_in(tick_in),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data),
        .irq_valid(irq_valid), .irq_vector(irq_vector)
    );

    always #4 clk = ~clk;  // 125 MHz

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] sel, logic [31:0] data, output int w);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(posedge clk);
        #1;
        w = cyc;
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [1:0] sel, output logic [31:0] v);
        rd_sel = sel;
        #1;
        v = rd_data;
        rd_sel = 2'd3;
    endtask

    task automatic expect_irq(int c, logic [7:0] v, string tag);
        exp_cyc.push_back(c);
        exp_vec.push_back(v);
        exp_tag.push_back(tag);
    endtask

    task automatic wait_until(int c);
        while (cyc < c) @(negedge clk);
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (exp_cyc.size() > 0 && exp_cyc[0] < cyc) begin
                checks++; errors++;
                $display("FAIL %s missed request actual=none expected_cycle=%0d", exp_tag[0], exp_cyc[0]);
                void'(exp_cyc.pop_front()); void'(exp_vec.pop_front()); void'(exp_tag.pop_front());
            end
            if (irq_valid) begin
                checks++;
                if (exp_cyc.size() == 0) begin
                    errors++;
                    $display("FAIL R8/R9 unexpected request actual_cycle=%0d expected=none", cyc);
                end else begin
                    if (exp_cyc[0] != cyc || irq_vector !== exp_vec[0]) begin
                        errors++;
                        $display("FAIL %s actual_cycle=%0d vec=%h expected_cycle=%0d vec=%h",
                                 exp_tag[0], cyc, irq_vector, exp_cyc[0], exp_vec[0]);
                    end
                    if (rd_sel == 2'd3 && rd_data !== 32'd0) begin
                        errors++;
                        $display("FAIL R9 count at request actual=%h expected=0", rd_data);
                    end
                    void'(exp_cyc.pop_front()); void'(exp_vec.pop_front()); void'(exp_tag.pop_front());
                end
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        if (cyc == 100000 && !done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int w, w2, v;
        logic [31:0] r;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(2'd1, r); chk("R1 entry", r, 32'h0001_0000);
        rd(2'd0, r); chk("R1 divide", r, 32'h0);
        rd(2'd2, r); chk("R1 start", r, 32'h0);
        chk("R1 count", rd_data, 32'h0);
        chk("R1 irq", {31'b0, irq_valid}, 32'h0);

        // R2 divide bits kept
        wr(2'd0, 32'hFFFF_FFFF, w); rd(2'd0, r); chk("R2 all ones", r, 32'h0000_000B);
        wr(2'd0, 32'hFFFF_FFF4, w); rd(2'd0, r); chk("R2 dropped bits", r, 32'h0);

        // R11 entry readback
        wr(2'd1, 32'hFFFF_FFFF, w); rd(2'd1, r); chk("R11 entry", r, 32'h0003_00FF);

        // R13 write to count select ignored
        wr(2'd3, 32'h1234_5678, w);
        rd(2'd1, r); chk("R13 entry kept", r, 32'h0003_00FF);
        rd(2'd2, r); chk("R13 start kept", r, 32'h0);
        chk("R13 count", rd_data, 32'h0);

        // R4 one-shot, divide by 1
        wr(2'd0, 32'hB, w);
        wr(2'd1, 32'h0000_0042, w);
        wr(2'd2, 32'd5, w);
        expect_irq(w + 5, 8'h42, "R4 one-shot");
        wait_until(w + 2); chk("R4 count midway", rd_data, 32'd3);
        wait_until(w + 20); chk("R4 saturated", rd_data, 32'd0);
        chk("R4 single request", exp_cyc.size(), 32'd0);

        // R3 divisor mapping
        wr(2'd0, 32'h0, w);  wr(2'd2, 32'd3, w); expect_irq(w + 6, 8'h42, "R3 div2");
        wait_until(w + 10);
        wr(2'd0, 32'h3, w);  wr(2'd2, 32'd1, w); expect_irq(w + 16, 8'h42, "R3 div16");
        wait_until(w + 20);
        wr(2'd0, 32'h8, w);  wr(2'd2, 32'd2, w); expect_irq(w + 64, 8'h42, "R3 div32");
        wait_until(w + 34); chk("R3 div32 count", rd_data, 32'd1);
        wait_until(w + 70);

        // R5 periodic, then R6 stop with zero
        wr(2'd0, 32'hB, w);
        wr(2'd1, 32'h0002_0077, w);
        wr(2'd2, 32'd3, w);
        expect_irq(w + 3, 8'h77, "R5 first");
        expect_irq(w + 7, 8'h77, "R5 second");
        expect_irq(w + 11, 8'h77, "R5 third");
        wait_until(w + 11);
        wr(2'd2, 32'd0, w);
        wait_until(w + 20); chk("R6 stopped count", rd_data, 32'd0);

        // R6 periodic with zero start value
        wr(2'd2, 32'd0, w);
        wait_until(w + 20); chk("R6 zero periodic", rd_data, 32'd0);

        // R8 masked one-shot keeps counting
        wr(2'd1, 32'h0001_0055, w);
        wr(2'd2, 32'd4, w);
        wait_until(w + 2); chk("R8 counts while masked", rd_data, 32'd2);
        wait_until(w + 10); chk("R8 masked end", rd_data, 32'd0);

        // R7 restart of count
        wr(2'd1, 32'h0000_0033, w);
        wr(2'd2, 32'd10, w);
        wait_until(w + 4);
        wr(2'd2, 32'd6, w2);
        expect_irq(w2 + 6, 8'h33, "R7 restart count");
        wait_until(w2 + 1); chk("R7 count reloaded", rd_data, 32'd5);
        wait_until(w2 + 12);

        // R7 restart of prescaler phase (divide by 2)
        wr(2'd0, 32'h0, w);
        wr(2'd2, 32'd2, w);
        repeat (2) @(posedge clk);
        wr(2'd2, 32'd2, w2);
        expect_irq(w2 + 4, 8'h33, "R7 restart phase");
        wait_until(w2 + 10);

        // R10 paused tick
        wr(2'd0, 32'hB, w);
        wr(2'd2, 32'd4, w);
        tick_in = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk("R10 paused count", rd_data, 32'd4);
        tick_in = 1'b1;
        expect_irq(w + 7, 8'h33, "R10 resumed");
        wait_until(w + 12);

        // R12 one-shot switched to periodic after expiry
        wr(2'd1, 32'h0000_0066, w);
        wr(2'd2, 32'd2, w);
        expect_irq(w + 2, 8'h66, "R12 first one-shot");
        wait_until(w + 5);
        wr(2'd1, 32'h0002_0066, v);
        expect_irq(v + 3, 8'h66, "R12 resumed");
        expect_irq(v + 6, 8'h66, "R12 periodic");
        wait_until(v + 6);
        wr(2'd2, 32'd0, w);
        wait_until(w + 15);
        chk("R12 stopped", rd_data, 32'd0);

        chk("R9 queue drained", exp_cyc.size(), 32'd0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule